// File: doc/BRIEF.md
# T1 Receive Framing Error Monitor

This block watches the framing bits of a T1 receive stream that an external synchronizer has already aligned. Each clock cycle carries one received bit. The synchronizer marks F-bit positions, the frame number within a 24-frame window, the bits of channel 24, and the F-bit positions that carry a data link. The monitor compares each checked bit with the pattern that the selected framing mode expects. It reports errors in three ways: a timed pulse on an error pin, a sticky flag, and a small saturating counter.

Four framing modes are supported. Each mode has its own set of checked bits, its own rule for which errors reach the pin and which are counted, and its own pulse timing. In the extended-superframe mode, a CRC mismatch strobe from an external checker also produces a short pulse on the pin. That pulse is launched on the falling clock edge.

Top module: `t1_frm_mon`

## Requirements
- R1: After reset, err_pin, err_sticky and err_cnt are all zero.
- R2: In mode 0 (superframe), the F-bits of odd frames must follow 1,0,1,0,1,0 over frames 1,3,5,7,9,11, repeating every 12 frames. When one of these bits is wrong in cycle k, err_pin is high in cycles k+1 and k+2, and the error is counted.
- R3: In mode 0, the F-bits of even frames must follow 0,0,1,1,1,0 over frames 2,4,6,8,10,12, repeating every 12 frames. When one of these bits is wrong, err_pin pulses with the R2 timing, but the counter and the sticky flag do not change.
- R4: In mode 1 (extended superframe), only the F-bits of frames 4,8,12,16,20,24 are checked, against 0,0,1,0,1,1. An error there pulses err_pin with the R2 timing and is counted. All other F-bits in this mode have no effect.
- R5: In mode 1, crc_err_stb high in cycle k drives err_pin high from the falling edge in cycle k to the falling edge in cycle k+1. In every other mode, crc_err_stb has no effect.
- R6: In mode 2 (SLC-96), odd-frame F-bits are checked and counted as in R2. Even-frame F-bits are checked as in R3 and reach only the pin. An even-frame F-bit with dl_pos high never affects the pin, the flag or the counter.
- R7: In mode 3 (T1DM), a wrong odd-frame or even-frame F-bit, or a channel-24 sync word mismatch, marks the frame as errored. At the F-bit of the next frame (cycle k), err_pin is high in cycles k+1 and k+2, and the errored frame is counted once.
- R8: In mode 3, the eight bits received with ch24_stb high form the sync word, first bit as the MSB. The word is compared with parameter SYNC_WORD (default 8'h9C).
- R9: err_sticky sets in the cycle after any counted error and holds until sts_clr. A counted error in the same cycle as sts_clr leaves it set.
- R10: err_cnt counts counted errors and saturates at 15. cnt_clr zeroes it in the next cycle, or loads 1 if a counted error arrives in the same cycle.
- R11: A reported error while the pulse is already running restarts the two-cycle window. For errors in cycles k and k+1, err_pin is high in cycles k+1 to k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Framing mode: 0 superframe, 1 extended superframe, 2 SLC-96, 3 T1DM |
| rx_bit | input | 1 | Received serial bit |
| fbit_stb | input | 1 | High when rx_bit is an F-bit |
| frame_num | input | 5 | Frame number 1 to 24 of the current F-bit |
| dl_pos | input | 1 | High when the current even-frame F-bit carries data link (mode 2) |
| ch24_stb | input | 1 | High for the bits of channel 24 |
| crc_err_stb | input | 1 | CRC mismatch of the previous superframe (mode 1) |
| cnt_clr | input | 1 | Clears the error counter |
| sts_clr | input | 1 | Clears the sticky flag |
| err_pin | output | 1 | Timed error pulse |
| err_sticky | output | 1 | Sticky framing error flag |
| err_cnt | output | 4 | Saturating framing error count |

## Verification
An F-bit error driven in cycle k is due on err_pin in cycles k+1 and k+2. In mode 3 the error is held back to the F-bit of the next frame and then follows the same timing. The counter and the sticky flag change in cycle k+1. A CRC strobe in cycle k shows up at the first sample of cycle k+1 only, because samples are taken one nanosecond after each rising edge, before the falling edge. The bench keeps its expectation as a list of recent trigger cycles and scheduled counter updates, and compares against it in every cycle, so an early, late, short or stretched pulse is reported as a mismatch.

// File: rtl/t1fm_pkg.sv
package t1fm_pkg;

   typedef enum logic [1:0] {
      FM_D4  = 2'd0,
      FM_ESF = 2'd1,
      FM_SLC = 2'd2,
      FM_DM  = 2'd3
   } fmode_e;

   // element 0 of each sequence sits in the MSB
   localparam logic [5:0] TERM_SEQ = 6'b101010;
   localparam logic [5:0] SIG_SEQ  = 6'b001110;
   localparam logic [5:0] FPS_SEQ  = 6'b001011;

   function automatic logic term_exp(input logic [4:0] fr);
      logic [2:0] i;
      i = 3'(((int'(fr) + 11) % 12) / 2);
      return TERM_SEQ[3'd5 - i];
   endfunction

   function automatic logic sig_exp(input logic [4:0] fr);
      logic [2:0] i;
      i = 3'(((int'(fr) + 10) % 12) / 2);
      return SIG_SEQ[3'd5 - i];
   endfunction

   function automatic logic fps_exp(input logic [4:0] fr);
      logic [2:0] i;
      if (fr < 5'd4 || fr > 5'd24) return 1'b0;
      i = 3'((int'(fr) / 4) - 1);
      return FPS_SEQ[3'd5 - i];
   endfunction

endpackage

// File: rtl/tfm_check.sv
module tfm_check
   import t1fm_pkg::*;
(
   input  fmode_e     mode,
   input  logic       rx_bit,
   input  logic       fbit_stb,
   input  logic [4:0] frame_num,
   input  logic       dl_pos,
   output logic       pin_err,
   output logic       cnt_err,
   output logic       dm_err
);

   logic odd_fr, fps_slot;
   logic bad_term, bad_sig, bad_fps;

   assign odd_fr   = frame_num[0];
   assign fps_slot = (frame_num[1:0] == 2'b00) && (frame_num != 5'd0);
   assign bad_term = fbit_stb &&  odd_fr && (rx_bit != term_exp(frame_num));
   assign bad_sig  = fbit_stb && !odd_fr && (rx_bit != sig_exp(frame_num));
   assign bad_fps  = fbit_stb && fps_slot && (rx_bit != fps_exp(frame_num));

   always_comb begin
      pin_err = 1'b0;
      cnt_err = 1'b0;
      dm_err  = 1'b0;
      unique case (mode)
         FM_D4: begin
            pin_err = bad_term || bad_sig;
            cnt_err = bad_term;
         end
         FM_ESF: begin
            pin_err = bad_fps;
            cnt_err = bad_fps;
         end
         FM_SLC: begin
            pin_err = bad_term || (bad_sig && !dl_pos);
            cnt_err = bad_term;
         end
         FM_DM: begin
            dm_err = bad_term || bad_sig;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/tfm_syncw.sv
module tfm_syncw #(
   parameter int                SYNC_W    = 8,
   parameter logic [SYNC_W-1:0] SYNC_WORD = 8'h9C
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fbit_stb,
   input  logic ch24_stb,
   input  logic rx_bit,
   output logic sync_err
);

   localparam int BW = $clog2(SYNC_W);

   generate
      if (SYNC_W < 2) begin : g_bad_w
         $error("tfm_syncw: SYNC_W must be at least 2");
      end
   endgenerate

   logic [SYNC_W-1:0] sr;
   logic [BW-1:0]     bc;
   logic [SYNC_W-1:0] word_nxt;
   logic              last_bit;

   assign word_nxt = {sr[SYNC_W-2:0], rx_bit};
   assign last_bit = ch24_stb && (bc == BW'(SYNC_W - 1));
   assign sync_err = en && last_bit && (word_nxt != SYNC_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
         bc <= '0;
      end else if (!en || fbit_stb) begin
         bc <= '0;
      end else if (ch24_stb) begin
         sr <= word_nxt;
         bc <= last_bit ? '0 : bc + BW'(1);
      end
   end

endmodule

// File: rtl/tfm_pulse.sv
module tfm_pulse #(
   parameter int HOLD   = 2,
   parameter bit CRC_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic crc_trig,
   output logic pin
);

   localparam int HW = $clog2(HOLD + 1);

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("tfm_pulse: HOLD must be at least 1");
      end
   endgenerate

   logic [HW-1:0] hcnt;
   logic          f_on, crc_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hcnt <= '0;
      else if (trig)         hcnt <= HW'(HOLD);
      else if (hcnt != '0)   hcnt <= hcnt - HW'(1);
   end

   assign f_on = (hcnt != '0);

   generate
      if (CRC_EN) begin : g_crc
         logic crc_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) crc_q <= 1'b0;
            else        crc_q <= crc_trig;
         end
         assign crc_on = crc_q;

         AST_CRC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            crc_q |-> crc_trig);                                   // R5
      end else begin : g_no_crc
         assign crc_on = 1'b0;
      end
   endgenerate

   assign pin = f_on || crc_on;

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> f_on);                                              // R2
   AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (hcnt == HW'(HOLD)));                               // R11

endmodule

// File: rtl/tfm_errcnt.sv
module tfm_errcnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             cnt_clr,
   input  logic             sts_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             sticky
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_cw
         $error("tfm_errcnt: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (cnt_clr)            cnt <= inc ? CNT_W'(1) : '0;
      else if (inc && cnt != CMAX) cnt <= cnt + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sticky <= 1'b0;
      else if (inc)     sticky <= 1'b1;
      else if (sts_clr) sticky <= 1'b0;
   end

   AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CMAX && !cnt_clr) |=> (cnt == CMAX));                // R10
   AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (cnt <= CNT_W'(1)));                             // R10
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky && !sts_clr) |=> sticky);                            // R9

endmodule

// File: rtl/t1_frm_mon.sv
module t1_frm_mon
   import t1fm_pkg::*;
#(
   parameter int                CNT_W     = 4,
   parameter int                SYNC_W    = 8,
   parameter logic [SYNC_W-1:0] SYNC_WORD = 8'h9C,
   parameter int                HOLD      = 2,
   parameter bit                CRC_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             rx_bit,
   input  logic             fbit_stb,
   input  logic [4:0]       frame_num,
   input  logic             dl_pos,
   input  logic             ch24_stb,
   input  logic             crc_err_stb,
   input  logic             cnt_clr,
   input  logic             sts_clr,
   output logic             err_pin,
   output logic             err_sticky,
   output logic [CNT_W-1:0] err_cnt
);

   fmode_e fm;
   logic   pin_err, cnt_err, dm_err, sync_err;
   logic   is_dm, dm_pend, dm_fire;
   logic   trig, inc, crc_trig;

   assign fm    = fmode_e'(mode);
   assign is_dm = (fm == FM_DM);

   tfm_check u_check (
      .mode      (fm),
      .rx_bit    (rx_bit),
      .fbit_stb  (fbit_stb),
      .frame_num (frame_num),
      .dl_pos    (dl_pos),
      .pin_err   (pin_err),
      .cnt_err   (cnt_err),
      .dm_err    (dm_err)
   );

   tfm_syncw #(.SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)) u_syncw (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (is_dm),
      .fbit_stb (fbit_stb),
      .ch24_stb (ch24_stb),
      .rx_bit   (rx_bit),
      .sync_err (sync_err)
   );

   // one-frame deferral of T1DM errors
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dm_pend <= 1'b0;
      else if (!is_dm)   dm_pend <= 1'b0;
      else if (fbit_stb) dm_pend <= dm_err;
      else if (sync_err) dm_pend <= 1'b1;
   end

   assign dm_fire  = is_dm && fbit_stb && dm_pend;
   assign trig     = pin_err || dm_fire;
   assign inc      = cnt_err || dm_fire;
   assign crc_trig = (fm == FM_ESF) && crc_err_stb;

   tfm_pulse #(.HOLD(HOLD), .CRC_EN(CRC_EN)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig),
      .crc_trig (crc_trig),
      .pin      (err_pin)
   );

   tfm_errcnt #(.CNT_W(CNT_W)) u_errcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc),
      .cnt_clr (cnt_clr),
      .sts_clr (sts_clr),
      .cnt     (err_cnt),
      .sticky  (err_sticky)
   );

   AST_DL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (fm == FM_SLC && fbit_stb && !frame_num[0] && dl_pos && !cnt_clr)
      |=> $stable(err_cnt));                                       // R6
   AST_ESF_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (fm == FM_ESF && fbit_stb && frame_num[1:0] != 2'b00 && !cnt_clr)
      |=> $stable(err_cnt));                                       // R4
   AST_DM_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dm && fbit_stb && !dm_pend && !cnt_clr) |=> $stable(err_cnt)); // R7

endmodule

// File: tb/t1_frm_mon_tb_top.sv
module t1_frm_mon_tb_top;

   localparam logic [7:0] SW = 8'h9C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       rx_bit = 1'b0, fbit_stb = 1'b0, dl_pos = 1'b0, ch24_stb = 1'b0;
   logic [4:0] frame_num = 5'd1;
   logic       crc_err_stb = 1'b0, cnt_clr = 1'b0, sts_clr = 1'b0;
   logic       err_pin, err_sticky;
   logic [3:0] err_cnt;

   always #2 clk = ~clk;

   t1_frm_mon #(.SYNC_WORD(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .rx_bit(rx_bit),
      .fbit_stb(fbit_stb), .frame_num(frame_num), .dl_pos(dl_pos),
      .ch24_stb(ch24_stb), .crc_err_stb(crc_err_stb), .cnt_clr(cnt_clr),
      .sts_clr(sts_clr), .err_pin(err_pin), .err_sticky(err_sticky),
      .err_cnt(err_cnt));

   int    n_chk = 0, n_fail = 0;
   int    cyc = 0;
   int    trg_a = -10, trg_b = -10, crc_at = -10;
   int    m_cnt = 0;
   bit    m_sticky = 0, inc_q = 0, cclr_q = 0, sclr_q = 0, pend = 0;
   int    fr = 1;
   string tag = "R1";
   bit    done = 0;

   localparam logic [5:0] T_SEQ = 6'b101010;
   localparam logic [5:0] S_SEQ = 6'b001110;
   localparam logic [5:0] P_SEQ = 6'b001011;

   function automatic logic want_fbit(input int md, input int f);
      if (f % 2 == 1) return T_SEQ[5 - ((f - 1) % 12) / 2];
      if (md == 1 && f % 4 == 0) return P_SEQ[5 - (f / 4 - 1)];
      return S_SEQ[5 - ((f - 2) % 12) / 2];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d",
                  req, what, cyc, act, exp);
      end
   endtask

   task automatic fire();
      trg_b = trg_a;
      trg_a = cyc;
   endtask

   // advance one cycle, update the model for the edge, check, release inputs
   task automatic tick();
      bit ep;
      @(posedge clk);
      #1;
      cyc++;
      if (cclr_q)                  m_cnt = inc_q ? 1 : 0;
      else if (inc_q && m_cnt < 15) m_cnt++;
      if (inc_q)       m_sticky = 1;
      else if (sclr_q) m_sticky = 0;
      ep = ((cyc - trg_a) == 1) || ((cyc - trg_a) == 2) ||
           ((cyc - trg_b) == 1) || ((cyc - trg_b) == 2) ||
           ((cyc - crc_at) == 1);
      chk(err_pin == ep, tag, "err_pin", int'(err_pin), int'(ep));
      chk(int'(err_cnt) == m_cnt, tag, "err_cnt", int'(err_cnt), m_cnt);
      chk(err_sticky == m_sticky, tag, "err_sticky", int'(err_sticky), int'(m_sticky));
      inc_q = 0; cclr_q = 0; sclr_q = 0;
      fbit_stb = 0; ch24_stb = 0; dl_pos = 0; crc_err_stb = 0;
      cnt_clr = 0; sts_clr = 0; rx_bit = 1'($urandom);
   endtask

   task automatic do_frame(input bit bad_f, input bit bad_s, input bit dl,
                           input bit crc, input bit cc, input bit sc);
      int  md;
      bit  e, odd;
      md = int'(mode);
      odd = (fr % 2 == 1);
      tick();
      fbit_stb = 1; frame_num = 5'(fr); dl_pos = dl;
      cnt_clr = cc; cclr_q = cc; sts_clr = sc; sclr_q = sc;
      e = want_fbit(md, fr);
      rx_bit = bad_f ? ~e : e;
      case (md)
         0: if (bad_f) begin fire(); if (odd) inc_q = 1; end          // R2 R3
         1: if (fr % 4 == 0) begin
               if (bad_f) begin fire(); inc_q = 1; end                 // R4
            end else rx_bit = 1'($urandom);
         2: if (odd) begin
               if (bad_f) begin fire(); inc_q = 1; end
            end else if (dl) rx_bit = 1'($urandom);                  // R6
            else if (bad_f) fire();
         default: begin
            if (pend) begin fire(); inc_q = 1; end                   // R7
            pend = bad_f;
         end
      endcase
      for (int i = 0; i < 8; i++) begin
         tick();
         ch24_stb = 1;
         rx_bit = SW[7 - i] ^ (bad_s && i == 3);                     // R8
      end
      if (md == 3 && bad_s) pend = 1;
      tick();
      if (crc) begin
         crc_err_stb = 1;
         if (md == 1) crc_at = cyc;                                  // R5
      end
      fr = (fr % 24) + 1;
   endtask

   task automatic set_mode(input int md, input string t);
      tick();
      mode = 2'(md);
      pend = 0;
      tag = t;
      tick();
      tick();
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk(err_pin == 1'b0 && err_sticky == 1'b0 && err_cnt == 4'd0, "R1",
          "reset outputs", int'({err_pin, err_sticky, err_cnt}), 0);
      tag = "R1";
      tick(); tick();

      // R2 R3: superframe, clean then random
      set_mode(0, "R2");
      for (int f = 0; f < 24; f++) do_frame(0, 0, 0, 0, 0, 0);
      tag = "R3";
      for (int f = 0; f < 60; f++)
         do_frame(($urandom % 4) == 0, 0, 0, 0, ($urandom % 8) == 0, ($urandom % 8) == 0);

      // R11: errors on two back-to-back F-bits
      tag = "R11";
      tick();
      fbit_stb = 1; frame_num = 5'd1; rx_bit = 1'b0; fire(); inc_q = 1;
      tick();
      fbit_stb = 1; frame_num = 5'd3; rx_bit = 1'b1; fire(); inc_q = 1;
      repeat (5) tick();

      // R10: saturation, then clear together with an error
      tag = "R10";
      fr = 1;
      for (int f = 0; f < 40; f++) do_frame(fr % 2 == 1, 0, 0, 0, 0, 0);
      fr = 1;
      do_frame(1, 0, 0, 0, 1, 0);
      do_frame(0, 0, 0, 0, 1, 0);
      // R9: clear together with an error keeps the flag; clear alone drops it
      tag = "R9";
      fr = 1;
      do_frame(1, 0, 0, 0, 0, 1);
      do_frame(0, 0, 0, 0, 0, 1);
      do_frame(0, 0, 0, 0, 0, 0);

      // R4 R5: extended superframe
      set_mode(1, "R4");
      fr = 1;
      for (int f = 0; f < 96; f++)
         do_frame(($urandom % 3) == 0, 0, 0, fr == 24 && ($urandom % 2) == 0,
                  ($urandom % 10) == 0, ($urandom % 10) == 0);
      tag = "R5";
      for (int f = 0; f < 24; f++) do_frame(0, 0, 0, fr == 24, 0, 0);

      // R6: SLC-96 with data-link positions
      set_mode(2, "R6");
      fr = 1;
      for (int f = 0; f < 96; f++)
         do_frame(($urandom % 3) == 0, 0, ($urandom % 2) == 0, ($urandom % 6) == 0,
                  ($urandom % 10) == 0, ($urandom % 10) == 0);

      // R7 R8: T1DM with deferred reporting and sync word errors
      set_mode(3, "R7");
      fr = 1;
      for (int f = 0; f < 24; f++) do_frame(0, 0, 0, 0, 0, 0);
      tag = "R8";
      do_frame(0, 1, 0, 0, 0, 0);
      do_frame(0, 0, 0, 0, 0, 0);
      tag = "R7";
      for (int f = 0; f < 96; f++)
         do_frame(($urandom % 4) == 0, ($urandom % 4) == 0, 0, ($urandom % 6) == 0,
                  ($urandom % 10) == 0, ($urandom % 10) == 0);
      do_frame(0, 0, 0, 0, 0, 0);
      do_frame(0, 0, 0, 0, 0, 0);
      repeat (4) tick();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule